// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a single-port synchronous SRAM with a small internal array and a burst address generator. On each rising clock edge it samples the address, the two chip enables, the write controls and the burst controls. Read data is not registered on the way out. It leaves the array combinationally from the registered address, so a read started at one edge shows its word during the cycle that follows. Two address strobes start accesses. The processor-style strobe is gated by the primary enable and always starts a read. The controller-style strobe starts a read or a write according to the write controls, or deselects the device.

After a burst starts, an advance input steps a 2-bit counter. The counter produces the other three words of a four-word group in either linear or interleaved order, chosen by a static mode pin. While both strobes are idle and advance is high, the burst waits on its current address. Writes can hit any subset of four byte lanes, or all lanes through a global write. An asynchronous output enable and a snooze input gate the output. The output is modelled as a data bus that reads zero whenever it would be high-impedance, plus a valid flag. The block has no back-pressure: the bus master owns the timing and the array answers in the same cycle. For that reason the data path carries a valid flag and no ready signal.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high at a clock edge, the device becomes deselected and the burst counter is cleared. After that edge, `rdata_valid` is 0 and `rdata` is 0.
- R2: When `strobe_cpu_n` is 0, `sel_n` is 0 and `sel_hi` is 1 at an edge, a read of the word at `addr` starts, whatever the write controls are. No word is written at that edge.
- R3: Take a cycle that follows a processor-strobe read, with both strobes at 1 and `adv_n` at 1. If the write controls are active in that cycle, the edge writes `wdata` to the address captured by the strobe.
- R4: When `strobe_ctl_n` is 0 and the processor strobe is not in effect, the edge loads `addr` and starts a write (write controls active) or a read (write controls inactive) if `sel_n`=0 and `sel_hi`=1. If either enable is inactive, the device is deselected instead, and it stays deselected through later continue cycles.
- R5: While `sel_n` is 1, the processor strobe has no effect. With `strobe_ctl_n` at 1, the current burst goes on as a continue or wait cycle.
- R6: In a cycle with both strobes idle, `adv_n`=0 steps the burst counter and `adv_n`=1 keeps the current address. This holds whatever `sel_n` and `sel_hi` are, and only the low two address bits ever change.
- R7: With `interleave`=0, the word offsets (low two address bits) of a burst are start, start+1, start+2, start+3, each taken modulo 4. A fifth step returns to start.
- R8: With `interleave`=1, the word offsets of a burst are start XOR 0, 1, 2 and 3 in that order. A fifth step returns to start.
- R9: Lane i is `wdata[9i+8:9i]`. If `gwrite_n`=0, every lane is written. Otherwise, when `bwen_n`=0, only the lanes whose `lane_we_n` bit is 0 are written. When `bwen_n`=1 and `gwrite_n`=1, the cycle is a read and no lane changes.
- R10: `rdata_valid` is 0 and `rdata` is 0 in each of these cases: `out_en_n` is 1 (this takes effect without waiting for a clock), the device is deselected, or the current cycle is a write.
- R11: While `snooze` is 1, the outputs are invalid at once. Edges taken during snooze perform no access and leave the burst address and operation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| snooze | input | 1 | Standby request, active high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sel_n | input | 1 | Primary chip enable, active low, gates the processor strobe |
| sel_hi | input | 1 | Secondary chip enable, active high |
| strobe_cpu_n | input | 1 | Processor-style address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-style address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| gwrite_n | input | 1 | Global write of all lanes, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write select, active low |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, zero when not driven |
| rdata_valid | output | 1 | Read data is being driven |

## Verification
The bound checker watches a set of rules on every clock. Output enable and snooze must force the output invalid. A wait or snooze cycle must freeze the burst address. A linear step must add one to the low two bits and leave the upper bits alone. A selected processor strobe must land in a read of the strobed address, and a controller strobe with an inactive enable must leave the output invalid. Memory contents can only be judged from the words read back, so the bench's scenarios have to show several things. They cover both burst orders from all four start offsets and the wrap at the end, the write on the wait cycle after a processor strobe, the merge of a partial byte write, and proof that neither a read-only strobe nor snooze writes anything.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst for the given start offset and count.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] count,
                                           input logic       interleave);
    return interleave ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snooze,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             adv_n,
  input  logic             gwrite_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic             load,
  output logic             step,
  output logic             wr_en,
  output logic [LANES-1:0] wr_mask,
  output sbs_pkg::op_e     op_q
);
  import sbs_pkg::*;

  op_e  op_d;
  logic cpu_go, ctl_go, chip_on, wr_req;

  assign cpu_go  = !strobe_cpu_n && !sel_n;
  assign ctl_go  = !cpu_go && !strobe_ctl_n;
  assign chip_on = !sel_n && sel_hi;
  assign wr_mask = !gwrite_n ? '1 : (!bwen_n ? ~lane_we_n : '0);
  assign wr_req  = |wr_mask;

  always_comb begin
    op_d = op_q;
    load = 1'b0;
    step = 1'b0;
    if (snooze) begin
      op_d = op_q;
    end else if (cpu_go) begin
      load = chip_on;
      op_d = chip_on ? OP_READ : OP_IDLE;
    end else if (ctl_go) begin
      load = chip_on;
      op_d = chip_on ? (wr_req ? OP_WRITE : OP_READ) : OP_IDLE;
    end else if (op_q != OP_IDLE) begin
      step = !adv_n;
      op_d = wr_req ? OP_WRITE : OP_READ;
    end
  end

  assign wr_en = !snooze && (op_d == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_IDLE;
    else     op_q <= op_d;
  end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          interleave,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q, hi_d;
  logic [1:0]    base_q, base_d, cnt_q, cnt_d;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      hi_d   = ext_addr[AW-1:2];
      base_d = ext_addr[1:0];
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  assign cur_addr = {hi_q, sbs_pkg::burst_low(base_q, cnt_q, interleave)};
  assign nxt_addr = {hi_d, sbs_pkg::burst_low(base_d, cnt_d, interleave)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  parameter int LW    = 9,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [LANES-1:0]    wr_mask,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) store[wr_addr] <= wr_data[g*LW +: LW];
    end

    assign rd_data[g*LW +: LW] = store[rd_addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  parameter int LANES = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snooze,
  input  logic             interleave,
  input  logic             out_en_n,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  logic             gwrite_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             rdata_valid
);
  localparam int LW = WIDTH / LANES;

  sbs_pkg::op_e     op_q;
  logic             load, step, wr_en;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [WIDTH-1:0] arr_q;

  sbs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .snooze(snooze), .sel_n(sel_n), .sel_hi(sel_hi),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_we_n(lane_we_n),
    .load(load), .step(step), .wr_en(wr_en), .wr_mask(wr_mask), .op_q(op_q)
  );

  sbs_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .load(load), .step(step), .interleave(interleave),
    .ext_addr(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  sbs_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW), .AW(AW)) u_arr (
    .clk(clk), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(nxt_addr),
    .wr_data(wdata), .rd_addr(cur_addr), .rd_data(arr_q)
  );

  assign rdata_valid = (op_q == sbs_pkg::OP_READ) && !out_en_n && !snooze;
  assign rdata       = rdata_valid ? arr_q : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int WIDTH = 36,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             snooze,
  input logic             interleave,
  input logic             out_en_n,
  input logic             sel_n,
  input logic             sel_hi,
  input logic             strobe_cpu_n,
  input logic             strobe_ctl_n,
  input logic             adv_n,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] rdata,
  input logic             rdata_valid,
  input logic [AW-1:0]    cur_addr,
  input sbs_pkg::op_e     op_q
);
  logic both_idle;
  assign both_idle = (strobe_cpu_n || sel_n) && strobe_ctl_n;

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!rdata_valid && rdata == '0));

  assert_snooze_out_R11: assert property (@(posedge clk) disable iff (rst)
    snooze |-> !rdata_valid);

  assert_snooze_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    snooze |=> ($stable(cur_addr) && $stable(op_q)));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!snooze && both_idle && adv_n) |=> $stable(cur_addr));

  assert_step_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (!snooze && both_idle) |=> $stable(cur_addr[AW-1:2]));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!snooze && both_idle && !adv_n && op_q != sbs_pkg::OP_IDLE && !interleave)
    |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!snooze && !strobe_cpu_n && !sel_n && sel_hi)
    |=> (op_q == sbs_pkg::OP_READ && cur_addr == $past(addr)));

  assert_ctl_desel_R4: assert property (@(posedge clk) disable iff (rst)
    (!snooze && !(!strobe_cpu_n && !sel_n) && !strobe_ctl_n && !(!sel_n && sel_hi))
    |=> !rdata_valid);

endmodule

bind burst_sram burst_sram_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (.*);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snooze = 1'b0, interleave = 1'b0, out_en_n = 1'b0;
  logic        sel_n = 1'b0, sel_hi = 1'b1;
  logic        strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        gwrite_n = 1'b1, bwen_n = 1'b1;
  logic [3:0]  lane_we_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_valid;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rst(rst), .snooze(snooze), .interleave(interleave),
    .out_en_n(out_en_n), .sel_n(sel_n), .sel_hi(sel_hi),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .addr(addr), .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_we_n(lane_we_n),
    .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid)
  );

  // {interleave, start, offset0, offset1, offset2, offset3}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 8'b00_01_10_11}, {1'b0, 2'd1, 8'b01_10_11_00},
    {1'b0, 2'd2, 8'b10_11_00_01}, {1'b0, 2'd3, 8'b11_00_01_10},
    {1'b1, 2'd0, 8'b00_01_10_11}, {1'b1, 2'd1, 8'b01_00_11_10},
    {1'b1, 2'd2, 8'b10_11_00_01}, {1'b1, 2'd3, 8'b11_10_01_00}
  };

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {a, 1'b0, ~a, 1'b1, a ^ 8'h3C, 1'b0, a ^ 8'hA5, 1'b1};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic chk(input string tag, input logic [36:0] exp);
    n_chk++;
    if ({rdata_valid, rdata} !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, {rdata_valid, rdata}, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    gwrite_n = 1'b1; bwen_n = 1'b1; lane_we_n = 4'hF;
    sel_n = 1'b0; sel_hi = 1'b1; out_en_n = 1'b0; snooze = 1'b0; wdata = '0;
  endtask

  task automatic cpu_read(input logic [7:0] a);
    idle(); strobe_cpu_n = 1'b0; addr = a; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) cyc();
    chk("R1 reset output", {1'b0, 36'h0});
    rst = 1'b0;
    cyc();
    chk("R1 idle after reset", {1'b0, 36'h0});

    // Fill words 0..127 with controller-strobe global writes (R4, R9)
    for (int a = 0; a < 128; a++) begin
      idle(); strobe_ctl_n = 1'b0; addr = 8'(a); gwrite_n = 1'b0; wdata = pat(8'(a));
      cyc();
      if (a == 0) chk("R10 output off in write cycle", {1'b0, 36'h0});
    end
    idle(); strobe_ctl_n = 1'b0; addr = 8'h07; cyc();
    chk("R4 controller strobe read", {1'b1, pat(8'h07)});

    // Burst order table: R7 linear, R8 interleaved
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      string tg;
      v = VEC[i];
      tg = v[10] ? "R8 burst order" : "R7 burst order";
      interleave = v[10];
      cpu_read({6'd1, v[9:8]});
      chk(tg, {1'b1, pat({6'd1, v[7:6]})});
      for (int k = 1; k < 4; k++) begin
        idle(); adv_n = 1'b0; cyc();
        chk(tg, {1'b1, pat({6'd1, v[7 - 2*k -: 2]})});
      end
      idle(); adv_n = 1'b0; cyc();
      chk(tg, {1'b1, pat({6'd1, v[7:6]})});
    end
    interleave = 1'b0;

    // R6 wait keeps address, advance ignores enables
    cpu_read(8'h20);
    chk("R6 burst start", {1'b1, pat(8'h20)});
    idle(); cyc();
    chk("R6 wait holds", {1'b1, pat(8'h20)});
    idle(); adv_n = 1'b0; sel_n = 1'b1; sel_hi = 1'b0; cyc();
    chk("R6 advance with enables off", {1'b1, pat(8'h21)});

    // R5 processor strobe ignored while primary enable high
    idle(); sel_n = 1'b1; strobe_cpu_n = 1'b0; addr = 8'h40; adv_n = 1'b0; cyc();
    chk("R5 strobe ignored, burst continues", {1'b1, pat(8'h22)});

    // R2 processor strobe reads even with write asserted
    idle(); strobe_cpu_n = 1'b0; addr = 8'h30; gwrite_n = 1'b0; wdata = '0; cyc();
    chk("R2 read despite write", {1'b1, pat(8'h30)});
    idle(); cyc();
    chk("R2 word unchanged", {1'b1, pat(8'h30)});

    // R3 write on the wait cycle after the processor strobe
    cpu_read(8'h31);
    chk("R3 strobe read", {1'b1, pat(8'h31)});
    idle(); gwrite_n = 1'b0; wdata = 36'h9_1234_5678; cyc();
    chk("R10 output off on write", {1'b0, 36'h0});
    idle(); cyc();
    chk("R3 wait-cycle write", {1'b1, 36'h9_1234_5678});

    // R9 partial byte write: lanes 0 and 2 (lane_we_n = 1010)
    idle(); strobe_ctl_n = 1'b0; addr = 8'h50; bwen_n = 1'b0; lane_we_n = 4'b1010;
    wdata = 36'hF_0F0F_0F0F; cyc();
    idle(); cyc();
    begin
      logic [35:0] o, n;
      o = pat(8'h50); n = 36'hF_0F0F_0F0F;
      chk("R9 lane merge", {1'b1, o[35:27], n[26:18], o[17:9], n[8:0]});
    end
    idle(); strobe_ctl_n = 1'b0; addr = 8'h51; lane_we_n = 4'h0; wdata = '0; cyc();
    chk("R9 byte enable off reads", {1'b1, pat(8'h51)});
    idle(); cyc();
    chk("R9 no lane changed", {1'b1, pat(8'h51)});

    // R4 deselect through controller strobe
    idle(); strobe_ctl_n = 1'b0; addr = 8'h52; cyc();
    chk("R4 read before deselect", {1'b1, pat(8'h52)});
    idle(); strobe_ctl_n = 1'b0; sel_hi = 1'b0; addr = 8'h53; cyc();
    chk("R4 deselected", {1'b0, 36'h0});
    idle(); adv_n = 1'b0; cyc();
    chk("R4 stays deselected", {1'b0, 36'h0});

    // R10 asynchronous output enable
    cpu_read(8'h53);
    out_en_n = 1'b1; #1;
    chk("R10 output enable high", {1'b0, 36'h0});
    out_en_n = 1'b0; #1;
    chk("R10 output enable low", {1'b1, pat(8'h53)});

    // R11 snooze blocks access and freezes state
    cpu_read(8'h60);
    chk("R11 read before snooze", {1'b1, pat(8'h60)});
    snooze = 1'b1; adv_n = 1'b0; gwrite_n = 1'b0; #1;
    chk("R11 snooze output off", {1'b0, 36'h0});
    cyc();
    chk("R11 snooze after edge", {1'b0, 36'h0});
    idle(); #1;
    chk("R11 state and word held", {1'b1, pat(8'h60)});

    // R1 reset in mid-burst
    rst = 1'b1; cyc();
    chk("R1 reset mid-burst", {1'b0, 36'h0});
    rst = 1'b0; cyc();
    chk("R1 stays deselected", {1'b0, 36'h0});

    summary();
    $finish;
  end

endmodule